// File: doc/BRIEF.md
# Parallel Multi-Lane SPI ADC Scanner

This block reads a bank of serial ADCs that all share one chip select, one serial clock and one command line. Each converter returns its result on its own data-return lane. A frame timer starts a conversion frame at a fixed interval. In each frame the block sends one channel-select command to every converter at once and shifts in one 16-bit result from every lane in parallel. Between frames it steps the shared channel address through each converter's input multiplexer, so with N_CH inputs per converter every channel is revisited once every N_CH frames.

A converter applies the address received in one frame to the conversion it returns in the next frame. The block therefore tags each result with the channel it sent one frame earlier. The frame that follows reset carries no valid result and is dropped. Results of a frame leave on a valid/ready stream in ascending converter order. Each result carries the converter index, the channel index and a scan-start marker. A small FIFO covers stalls on that stream. Two sticky flags report a frame timer that is too fast for the serial timing and results lost to a full FIFO.

Top module: `mux_adc_scanner`

## Requirements
- R1: A frame drives chip select low, then gives exactly 16 serial clock periods in which the clock is high for SCLK_HALF system clocks and low for SCLK_HALF system clocks, starting and ending low. Chip select then stays high for at least 3 system clocks before the next frame. The serial clock is low whenever chip select is high.
- R2: Frames start every FRAME_PERIOD system clocks. The first frame starts right after reset is released.
- R3: The 16-bit command shifted out MSB first on the command line holds the channel address in its top CH_W bits, and every other bit is zero. The command line changes only while the serial clock is low. The address is 0 in the first frame after reset and rises by one each frame, wrapping from N_CH-1 to 0.
- R4: Every data-return lane is sampled when the serial clock rises, MSB first, so that the 16 sampled bits form that converter's result word.
- R5: A result captured in frame N is tagged with the channel address sent in frame N-1. No results from the first frame after reset are emitted.
- R6: Each frame emits exactly N_ADC results, for converter indices 0 to N_ADC-1 in ascending order. Lanes at index N_ADC and above never reach the output.
- R7: The scan-start marker is 1 exactly on the result with converter index 0 and channel 0, and 0 on every other result.
- R8: When the consumer stalls, results wait in a FIFO of FIFO_DEPTH (at least 16) entries. While valid is high and ready is low, the valid signal and all output fields hold steady. Buffered results leave in their original order.
- R9: A result that arrives while the FIFO is full and not being read is discarded and sets a drop flag that stays set until reset. Scanning and output continue after this.
- R10: If a frame start falls while the previous frame is still running, that start is skipped and an overrun flag is set, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_cs_no | output | 1 | Shared chip select, active low |
| spi_sclk_o | output | 1 | Shared serial clock, idles low |
| spi_mosi_o | output | 1 | Shared command line |
| spi_miso_i | input | LANES | One data-return lane per converter |
| smp_valid_o | output | 1 | Result available |
| smp_ready_i | input | 1 | Consumer accepts the result |
| smp_data_o | output | 16 | Result word |
| smp_adc_o | output | $clog2(LANES) | Converter index of the result |
| smp_ch_o | output | $clog2(N_CH) | Channel index of the result |
| smp_sos_o | output | 1 | Scan-start marker |
| overrun_o | output | 1 | Sticky: a frame start was skipped |
| drop_o | output | 1 | Sticky: a result was lost to a full FIFO |

## Verification
Two events can fall in the same cycle: the unloader writing a new frame's results into the FIFO, and the consumer reading the FIFO head. The bench provokes this by toggling ready in a fixed pattern during a long sweep, and checks that every result arrives in sequence with the expected converter, channel, data and marker. It then holds ready low for many frames so that pushes hit a full FIFO. After that it checks that the drop flag is set, that the first FIFO_DEPTH results after release continue the sequence with no gap, and that fresh results keep arriving.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int unsigned SAMPLE_W = 16;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/scan_frame_timer.sv
module scan_frame_timer #(
  parameter int unsigned PERIOD = 52
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == CNT_W'(PERIOD - 1)) cnt_d = '0;
    else                             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/scan_spi_engine.sv
module scan_spi_engine
  import adc_scan_pkg::*;
#(
  parameter int unsigned LANES     = 16,
  parameter int unsigned CH_W      = 6,
  parameter int unsigned SCLK_HALF = 1,
  parameter int unsigned GAP_CYC   = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic [CH_W-1:0]                    cmd_ch_i,
  input  logic [LANES-1:0]                   miso_i,
  output logic                               cs_no,
  output logic                               sclk_o,
  output logic                               mosi_o,
  output logic                               done_o,
  output logic                               miss_o,
  output logic [LANES-1:0][SAMPLE_W-1:0]     cap_o
);
  localparam int unsigned DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int unsigned GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int unsigned BIT_W = $clog2(SAMPLE_W);

  eng_state_e            state_q, state_d;
  logic [DIV_W-1:0]      div_q, div_d;
  logic [GAP_W-1:0]      gap_q, gap_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic                  sclk_q, sclk_d;
  logic                  cs_q, cs_d;
  logic [SAMPLE_W-1:0]   tx_q, tx_d;
  logic                  done_q, done_d;
  logic                  miss_q, miss_d;
  logic                  cap_en;
  logic [LANES-1:0][SAMPLE_W-1:0] rx_q;

  always_comb begin
    state_d = state_q;
    div_d   = div_q;
    gap_d   = gap_q;
    bit_d   = bit_q;
    sclk_d  = sclk_q;
    cs_d    = cs_q;
    tx_d    = tx_q;
    done_d  = 1'b0;
    miss_d  = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ENG_IDLE: begin
        if (start_i) begin
          state_d = ENG_SHIFT;
          cs_d    = 1'b0;
          div_d   = '0;
          bit_d   = '0;
          tx_d    = {cmd_ch_i, {(SAMPLE_W-CH_W){1'b0}}};
        end
      end
      ENG_SHIFT: begin
        miss_d = start_i;
        if (div_q == DIV_W'(SCLK_HALF - 1)) begin
          div_d  = '0;
          sclk_d = ~sclk_q;
          if (!sclk_q) begin
            cap_en = 1'b1;
          end else begin
            tx_d  = {tx_q[SAMPLE_W-2:0], 1'b0};
            bit_d = bit_q + 1'b1;
            if (bit_q == BIT_W'(SAMPLE_W - 1)) begin
              state_d = ENG_GAP;
              cs_d    = 1'b1;
              gap_d   = '0;
              done_d  = 1'b1;
            end
          end
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      ENG_GAP: begin
        miss_d = start_i;
        if (gap_q == GAP_W'(GAP_CYC - 1)) state_d = ENG_IDLE;
        else                               gap_d   = gap_q + 1'b1;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      div_q   <= '0;
      gap_q   <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      tx_q    <= '0;
      done_q  <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      gap_q   <= gap_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
      cs_q    <= cs_d;
      tx_q    <= tx_d;
      done_q  <= done_d;
      miss_q  <= miss_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rx_q[g] <= '0;
      else if (cap_en) rx_q[g] <= {rx_q[g][SAMPLE_W-2:0], miso_i[g]};
    end
  end

  assign cs_no  = cs_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[SAMPLE_W-1];
  assign done_o = done_q;
  assign miss_o = miss_q;
  assign cap_o  = rx_q;

  a_r1_sclk_low_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> !sclk_q);
  a_r1_deselect_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_q) |=> cs_q);
  a_r3_mosi_steady_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> $stable(tx_q[SAMPLE_W-1]));
endmodule

// File: rtl/scan_fifo.sv
module scan_fifo #(
  parameter int unsigned W     = 27,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  output logic         ovf_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] rdata_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q, cnt_d;
  logic          pop, full, wr_en;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign pop     = valid_o & ready_i;
  assign wr_en   = push_i & (~full | pop);
  assign ovf_o   = push_i & full & ~pop;
  assign rdata_o = mem_q[rd_q];

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en && !pop)      cnt_d = cnt_q + 1'b1;
    else if (!wr_en && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wr_q <= wr_q + 1'b1;
      if (pop)   rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q] <= wdata_i;
  end

  a_r8_stall_holds_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(rdata_o)));
  a_r8_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (AW+1)'(DEPTH));
endmodule

// File: rtl/mux_adc_scanner.sv
module mux_adc_scanner
  import adc_scan_pkg::*;
#(
  parameter int unsigned LANES        = 16,
  parameter int unsigned N_ADC        = 10,
  parameter int unsigned N_CH         = 64,
  parameter int unsigned SCLK_HALF    = 1,
  parameter int unsigned FRAME_PERIOD = 52,
  parameter int unsigned FIFO_DEPTH   = 16,
  localparam int unsigned ADC_W       = $clog2(LANES),
  localparam int unsigned CH_W        = $clog2(N_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                spi_cs_no,
  output logic                spi_sclk_o,
  output logic                spi_mosi_o,
  input  logic [LANES-1:0]    spi_miso_i,
  output logic                smp_valid_o,
  input  logic                smp_ready_i,
  output logic [SAMPLE_W-1:0] smp_data_o,
  output logic [ADC_W-1:0]    smp_adc_o,
  output logic [CH_W-1:0]     smp_ch_o,
  output logic                smp_sos_o,
  output logic                overrun_o,
  output logic                drop_o
);
  localparam int unsigned GAP_CYC = 2;
  localparam int unsigned ENT_W   = 1 + CH_W + ADC_W + SAMPLE_W;

  logic                            tick, done, miss, ovf;
  logic [LANES-1:0][SAMPLE_W-1:0]  cap;
  logic [LANES-1:0][SAMPLE_W-1:0]  hold_q;
  logic [CH_W-1:0]                 ch_q, ch_d, last_ch_q, last_ch_d, hold_ch_q, hold_ch_d;
  logic                            primed_q, primed_d, active_q, active_d, hold_en;
  logic [ADC_W-1:0]                idx_q, idx_d;
  logic                            ovr_q, drop_q;
  logic [ENT_W-1:0]                push_word, head_word;
  logic                            push_sos;

  scan_frame_timer #(.PERIOD(FRAME_PERIOD)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  scan_spi_engine #(
    .LANES    (LANES),
    .CH_W     (CH_W),
    .SCLK_HALF(SCLK_HALF),
    .GAP_CYC  (GAP_CYC)
  ) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tick),
    .cmd_ch_i(ch_q),
    .miso_i  (spi_miso_i),
    .cs_no   (spi_cs_no),
    .sclk_o  (spi_sclk_o),
    .mosi_o  (spi_mosi_o),
    .done_o  (done),
    .miss_o  (miss),
    .cap_o   (cap)
  );

  // channel sequencing and unload of one frame into the FIFO
  always_comb begin
    ch_d      = ch_q;
    last_ch_d = last_ch_q;
    hold_ch_d = hold_ch_q;
    primed_d  = primed_q;
    active_d  = active_q;
    idx_d     = idx_q;
    hold_en   = 1'b0;
    if (done) begin
      hold_en   = 1'b1;
      hold_ch_d = last_ch_q;
      last_ch_d = ch_q;
      ch_d      = (ch_q == CH_W'(N_CH - 1)) ? '0 : ch_q + 1'b1;
      primed_d  = 1'b1;
      if (primed_q) begin
        active_d = 1'b1;
        idx_d    = '0;
      end
    end else if (active_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == ADC_W'(N_ADC - 1)) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q      <= '0;
      last_ch_q <= '0;
      hold_ch_q <= '0;
      primed_q  <= 1'b0;
      active_q  <= 1'b0;
      idx_q     <= '0;
      hold_q    <= '0;
      ovr_q     <= 1'b0;
      drop_q    <= 1'b0;
    end else begin
      ch_q      <= ch_d;
      last_ch_q <= last_ch_d;
      hold_ch_q <= hold_ch_d;
      primed_q  <= primed_d;
      active_q  <= active_d;
      idx_q     <= idx_d;
      if (hold_en) hold_q <= cap;
      if (miss)    ovr_q  <= 1'b1;
      if (ovf)     drop_q <= 1'b1;
    end
  end

  assign push_sos  = (idx_q == '0) && (hold_ch_q == '0);
  assign push_word = {push_sos, hold_ch_q, idx_q, hold_q[idx_q]};

  scan_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (active_q),
    .wdata_i(push_word),
    .ovf_o  (ovf),
    .valid_o(smp_valid_o),
    .ready_i(smp_ready_i),
    .rdata_o(head_word)
  );

  assign {smp_sos_o, smp_ch_o, smp_adc_o, smp_data_o} = head_word;
  assign overrun_o = ovr_q;
  assign drop_o    = drop_q;

  a_r6_adc_index_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> (smp_adc_o < ADC_W'(N_ADC)));
  a_r7_sos_only_on_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && smp_sos_o) |-> (smp_adc_o == '0 && smp_ch_o == '0));
  a_r9_drop_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> drop_o);
  a_r10_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: tb/mux_adc_scanner_bench.sv
module mux_adc_scanner_bench;
  localparam int LN  = 16;
  localparam int NA  = 3;
  localparam int NC  = 8;
  localparam int CW  = 3;
  localparam int AW  = 4;
  localparam int HALF = 2;
  localparam int PER = 72;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          spi_cs_n, spi_sclk, spi_mosi;
  logic [LN-1:0] spi_miso;
  logic          out_valid, out_ready, out_sos, overrun, drop;
  logic [15:0]   out_data;
  logic [AW-1:0] out_adc;
  logic [CW-1:0] out_ch;

  mux_adc_scanner #(
    .LANES(LN), .N_ADC(NA), .N_CH(NC), .SCLK_HALF(HALF),
    .FRAME_PERIOD(PER), .FIFO_DEPTH(DEP)
  ) u_mux_adc_scanner (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_cs_no(spi_cs_n), .spi_sclk_o(spi_sclk), .spi_mosi_o(spi_mosi),
    .spi_miso_i(spi_miso),
    .smp_valid_o(out_valid), .smp_ready_i(out_ready), .smp_data_o(out_data),
    .smp_adc_o(out_adc), .smp_ch_o(out_ch), .smp_sos_o(out_sos),
    .overrun_o(overrun), .drop_o(drop)
  );

  // second instance whose frame interval is shorter than one frame
  logic          f_cs_n, f_sclk, f_mosi, f_valid, f_sos, f_ovr, f_drop;
  logic [15:0]   f_data;
  logic [AW-1:0] f_adc;
  logic [CW-1:0] f_ch;

  mux_adc_scanner #(
    .LANES(LN), .N_ADC(2), .N_CH(NC), .SCLK_HALF(1),
    .FRAME_PERIOD(20), .FIFO_DEPTH(DEP)
  ) u_fast (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_cs_no(f_cs_n), .spi_sclk_o(f_sclk), .spi_mosi_o(f_mosi),
    .spi_miso_i('0),
    .smp_valid_o(f_valid), .smp_ready_i(1'b1), .smp_data_o(f_data),
    .smp_adc_o(f_adc), .smp_ch_o(f_ch), .smp_sos_o(f_sos),
    .overrun_o(f_ovr), .drop_o(f_drop)
  );

  // converter models: address latched in one frame answers in the next
  logic [15:0]   m_sr [LN];
  logic [15:0]   m_cmd = '0;
  logic [CW-1:0] m_ch = '0;
  int            m_frame = -1;

  always @(negedge spi_cs_n) begin
    m_frame++;
    for (int i = 0; i < LN; i++)
      m_sr[i] = (i < NA) ? {4'(i), 1'b1, m_ch, 8'(m_frame)} : (16'hC3A5 ^ 16'(i * 77));
  end
  always @(posedge spi_cs_n) m_ch = m_cmd[15 -: CW];
  always @(posedge spi_sclk) m_cmd = {m_cmd[14:0], spi_mosi};
  always @(negedge spi_sclk) for (int i = 0; i < LN; i++) m_sr[i] = m_sr[i] << 1;

  for (genvar g = 0; g < LN; g++) begin : g_miso
    assign spi_miso[g] = m_sr[g][15];
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // serial timing monitor
  initial begin
    bit prev_cs = 1'b1;
    bit prev_sclk = 1'b0;
    int cyc = 0, last_fall = 0, last_rise_cs = 0, last_edge = 0, rises = 0, frame_k = 0;
    logic [15:0] mon_cmd = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cyc++;
        if (prev_cs && !spi_cs_n) begin
          if (frame_k > 0 && frame_k <= 8) begin
            check(cyc - last_fall == PER, "R2 frame interval", cyc - last_fall, PER);
            check(cyc - last_rise_cs >= 3, "R1 deselect gap", cyc - last_rise_cs, 3);
          end
          last_fall = cyc;
          last_edge = cyc;
          rises = 0;
        end
        if (spi_cs_n && spi_sclk)
          check(1'b0, "R1 clock high while deselected", 1, 0);
        if (!spi_cs_n && (spi_sclk != prev_sclk)) begin
          if (frame_k < 3) check(cyc - last_edge == HALF, "R1 half period", cyc - last_edge, HALF);
          last_edge = cyc;
          if (spi_sclk) begin
            rises++;
            mon_cmd = {mon_cmd[14:0], spi_mosi};
          end
        end
        if (!prev_cs && spi_cs_n) begin
          if (frame_k <= 10) begin
            check(rises == 16, "R1 clock count", rises, 16);
            check(mon_cmd == {3'(frame_k % NC), 13'b0}, "R3 command", mon_cmd, {3'(frame_k % NC), 13'b0});
          end
          last_rise_cs = cyc;
          frame_k++;
        end
        prev_cs = spi_cs_n;
        prev_sclk = spi_sclk;
      end
    end
  end

  // stream consumer
  bit stall = 1'b0;
  int check_limit = 1 << 30;
  int w_rx = 0;
  initial begin
    int cyc_n = 0;
    bit prev_vs = 1'b0;
    logic [31:0] prev_word = '0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cyc_n++;
        if (stall && prev_vs) begin
          check(out_valid == 1'b1, "R8 valid held", out_valid, 1);
          check({out_sos, out_ch, out_adc, out_data} == prev_word[23:0], "R8 fields held",
                {out_sos, out_ch, out_adc, out_data}, prev_word[23:0]);
        end
        out_ready = stall ? 1'b0 : ((cyc_n % 5) > 1);
        if (out_valid && out_ready) begin
          if (w_rx < check_limit) begin
            int f, l, c;
            f = 1 + w_rx / NA;
            l = w_rx % NA;
            c = (f - 1) % NC;
            check(out_data == {4'(l), 1'b1, 3'(c), 8'(f)}, "R4 R5 data", out_data, {4'(l), 1'b1, 3'(c), 8'(f)});
            check(out_adc == 4'(l), "R6 converter order", out_adc, l);
            check(out_ch == 3'(c), "R5 channel tag", out_ch, c);
            check(out_sos == (l == 0 && c == 0), "R7 scan start", out_sos, (l == 0 && c == 0));
          end
          w_rx++;
        end
        prev_vs = out_valid && !out_ready;
        prev_word = {8'b0, out_sos, out_ch, out_adc, out_data};
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    check(spi_cs_n == 1'b1, "R1 reset deselected", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R1 reset clock low", spi_sclk, 0);
    check(out_valid == 1'b0, "R8 reset empty", out_valid, 0);
    check(drop == 1'b0, "R9 reset drop", drop, 0);
    check(overrun == 1'b0, "R10 reset overrun", overrun, 0);
    rst_n = 1'b1;
    // first frame yields nothing (R5): no output before the second frame ends
    repeat (PER + 10) @(negedge clk);
    check(w_rx == 0 && out_valid == 1'b0, "R5 first frame dropped", w_rx, 0);
    wait (w_rx >= 20 * NA);
    @(negedge clk);
    check(drop == 1'b0, "R9 no drop while draining", drop, 0);
    check(overrun == 1'b0, "R10 no overrun at legal rate", overrun, 0);
    @(posedge clk);
    stall = 1'b1;
    check_limit = w_rx + DEP;
    repeat (12 * PER) @(posedge clk);
    @(negedge clk);
    check(drop == 1'b1, "R9 drop after overflow", drop, 1);
    @(posedge clk);
    stall = 1'b0;
    base = w_rx;
    repeat (6 * PER) @(posedge clk);
    @(negedge clk);
    check(w_rx >= base + DEP + 4 * NA, "R9 scanning continues", w_rx - base, DEP + 4 * NA);
    check(drop == 1'b1, "R9 drop sticky", drop, 1);
    check(f_ovr == 1'b1, "R10 overrun on short interval", f_ovr, 1);
    check(overrun == 1'b0, "R10 overrun stays clear", overrun, 0);
    finish_run();
  end
endmodule